// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a 10-bit successive-approximation converter. Software sees a small register file: a control word that holds the start/busy bit, the converter enable, the result format and the conversion-clock ratio; two 8-bit result registers; and a completion flag. Toward the analog side the block drives the sample/hold switch and a 10-bit trial code for the internal DAC, and it reads back one comparator bit.

A start request opens the sample/hold switch. The block waits one conversion-clock period and then resolves one result bit per period, from the most significant bit down. When the last bit is resolved, it loads the justified result, drops the busy bit, raises the flag and closes the switch so that acquisition resumes. Clearing the start bit, or clearing the enable, while a conversion is running abandons it. The result registers keep their old contents and acquisition starts again at once. While the converter is disabled, the result registers are plain storage for software.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A write to the control word (address 0) with bit 0 (start) and bit 1 (enable) both 1 starts a conversion, provided the enable was already 1 before that write and no conversion is running. On the next cycle control bit 0 reads 1, `go_busy` is 1 and `sample_closed` is 0.
- R2: A start request carried by the same write that changes the enable from 0 to 1 is ignored: `go_busy` stays 0.
- R3: The ratio field (control bits 4:3) sets the conversion-clock period N in system clocks: 0 gives 2, 1 gives 8, and 2 or 3 give 32. It is captured at the start. `go_busy` falls exactly 11·N cycles after the start edge: one settling period followed by ten bit periods.
- R4: During bit period k (9 down to 0), `dac_code` has bit k set, the bits above k hold the decisions already made and the bits below k are 0. The trial bit is kept when `cmp_in` is 1 in the last cycle of the period. `dac_code` is 0 whenever no conversion is running.
- R5: On the completion edge the result registers load, `go_busy` falls, the flag (address 3, bit 0) becomes 1 and `sample_closed` becomes 1.
- R6: With the format bit (control bit 2) at 1, the result is right-justified: high register (address 1) = {000000, b9, b8}, low register (address 2) = b7..b0.
- R7: With the format bit at 0, the result is left-justified: high register = b9..b2, low register = {b1, b0, 000000}.
- R8: A control write with bit 0 or bit 1 at 0 during a conversion aborts it. On the next cycle `go_busy` is 0 and `sample_closed` is 1, and the result registers and the flag are unchanged.
- R9: After an abort, a new start runs a complete conversion with the normal timing and result.
- R10: While the enable is 0, the two result registers read back whatever software last wrote, and no conversion result is ever loaded into them.
- R11: Writing 0 to flag bit 0 clears the flag. A completion in the same cycle wins, and the flag reads 1.
- R12: After reset, the control word, both result registers, the flag and `dac_code` are 0, and `sample_closed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read (0 control, 1 result high, 2 result low, 3 flag) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| go_busy | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Completion flag |
| sample_closed | output | 1 | 1 while the sample/hold switch connects the input |
| dac_code | output | 10 | Trial code for the DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial level |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is completion and a software clear of the flag. The bench places a flag write of 0 exactly on the computed completion edge of a conversion at ratio 2, then reads the flag: it must be 1. The second pair is completion and an abort, which the abort assertion judges whenever the two meet: the result and the flag must then stay put. The comparator is modelled as an ideal comparison of a chosen input code against `dac_code`, so every finished conversion must reproduce that code in the selected justification.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W = 10;
  localparam int REG_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RHI  = 2'd1;
  localparam logic [1:0] A_RLO  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  localparam int B_GO  = 0;
  localparam int B_EN  = 1;
  localparam int B_FMT = 2;
  localparam int B_SEL = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_tad_timer.sv
module sar_tad_timer #(
  parameter int DIV_LOG0 = 1,
  parameter int DIV_LOG1 = 3,
  parameter int DIV_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CNT_W = DIV_LOG2;
  localparam logic [CNT_W-1:0] LAST0 = CNT_W'((1 << DIV_LOG0) - 1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'((1 << DIV_LOG1) - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'((1 << DIV_LOG2) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (sel)
      2'd0:    last = LAST0;
      2'd1:    last = LAST1;
      default: last = LAST2;
    endcase
  end

  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine
  import sar_pkg::*;
#(
  parameter int W = RES_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic         cmp_in,
  output logic         busy,
  output logic         sh_closed,
  output logic [W-1:0] trial,
  output logic         done,
  output logic [W-1:0] word
);
  sar_state_t   st_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] dac_q;
  logic [W-1:0] kept;
  logic         sh_q;

  assign kept      = cmp_in ? dac_q : (dac_q & ~mask_q);
  assign word      = kept;
  assign busy      = (st_q != ST_IDLE);
  assign sh_closed = sh_q;
  assign trial     = dac_q;
  assign done      = (st_q == ST_CONV) && tick && mask_q[0] && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      dac_q  <= '0;
      sh_q   <= 1'b1;
    end else if (abort) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      dac_q  <= '0;
      sh_q   <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q <= ST_SETTLE;
            sh_q <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (tick) begin
            st_q   <= ST_CONV;
            mask_q <= {1'b1, {(W-1){1'b0}}};
            dac_q  <= {1'b1, {(W-1){1'b0}}};
          end
        end
        ST_CONV: begin
          if (tick) begin
            if (mask_q[0]) begin
              st_q   <= ST_IDLE;
              mask_q <= '0;
              dac_q  <= '0;
              sh_q   <= 1'b1;
            end else begin
              mask_q <= mask_q >> 1;
              dac_q  <= kept | (mask_q >> 1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_justify.sv
module sar_justify #(
  parameter int RW = 10,
  parameter int BW = 8
) (
  input  logic [RW-1:0] res,
  input  logic          right,
  output logic [BW-1:0] hi,
  output logic [BW-1:0] lo
);
  localparam int PAD = 2*BW - RW;
  logic [2*BW-1:0] pair;

  generate
    if (PAD > 0) begin : g_pad
      assign pair = right ? {{PAD{1'b0}}, res} : {res, {PAD{1'b0}}};
    end else begin : g_nopad
      assign pair = res[RW-1 -: 2*BW];
    end
  endgenerate

  assign hi = pair[2*BW-1:BW];
  assign lo = pair[BW-1:0];
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int DIV_LOG0 = 1,
  parameter int DIV_LOG1 = 3,
  parameter int DIV_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             go_busy,
  output logic             irq_flag,
  output logic             sample_closed,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in
);
  logic             en_q, fmt_q, flag_q;
  logic [1:0]       sel_q, conv_sel_q;
  logic [REG_W-1:0] res_hi_q, res_lo_q;
  logic             wr_ctrl, start_acc, abort, tick, conv_done;
  logic [RES_W-1:0] conv_word;
  logic [REG_W-1:0] fmt_hi, fmt_lo;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign start_acc = wr_ctrl && wr_data[B_GO] && wr_data[B_EN] && en_q && !go_busy;
  assign abort     = wr_ctrl && go_busy && !(wr_data[B_GO] && wr_data[B_EN]);

  sar_tad_timer #(
    .DIV_LOG0(DIV_LOG0), .DIV_LOG1(DIV_LOG1), .DIV_LOG2(DIV_LOG2)
  ) u_timer (
    .clk(clk), .rst(rst), .clear(start_acc), .run(go_busy),
    .sel(conv_sel_q), .tick(tick)
  );

  sar_step_engine #(.W(RES_W)) u_engine (
    .clk(clk), .rst(rst), .start(start_acc), .abort(abort), .tick(tick),
    .cmp_in(cmp_in), .busy(go_busy), .sh_closed(sample_closed),
    .trial(dac_code), .done(conv_done), .word(conv_word)
  );

  sar_justify #(.RW(RES_W), .BW(REG_W)) u_fmt (
    .res(conv_word), .right(fmt_q), .hi(fmt_hi), .lo(fmt_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      fmt_q      <= 1'b0;
      sel_q      <= 2'd0;
      conv_sel_q <= 2'd0;
      res_hi_q   <= '0;
      res_lo_q   <= '0;
      flag_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data[B_EN];
        fmt_q <= wr_data[B_FMT];
        sel_q <= wr_data[B_SEL +: 2];
      end
      if (start_acc) conv_sel_q <= wr_data[B_SEL +: 2];
      if (wr_en && addr == A_RHI) res_hi_q <= wr_data;
      if (wr_en && addr == A_RLO) res_lo_q <= wr_data;
      if (conv_done) begin
        res_hi_q <= fmt_hi;
        res_lo_q <= fmt_lo;
      end
      if (wr_en && addr == A_FLAG) flag_q <= wr_data[0];
      if (conv_done) flag_q <= 1'b1;
    end
  end

  assign irq_flag = flag_q;

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {{(REG_W-5){1'b0}}, sel_q, fmt_q, en_q, go_busy};
      A_RHI:   rd_data = res_hi_q;
      A_RLO:   rd_data = res_lo_q;
      default: rd_data = {{(REG_W-1){1'b0}}, flag_q};
    endcase
  end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk
  import sar_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [1:0]       wr_bits,
  input logic             go_busy,
  input logic             irq_flag,
  input logic             sample_closed,
  input logic [RES_W-1:0] dac_code,
  input logic             en_q,
  input logic             start_acc,
  input logic             conv_done,
  input logic [REG_W-1:0] res_hi_q,
  input logic [REG_W-1:0] res_lo_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == A_CTRL);

  a_r1_start_opens_switch: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> go_busy && !sample_closed);

  a_r2_enable_write_no_start: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !en_q |=> !go_busy);

  a_r4_dac_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !go_busy |-> dac_code == '0);

  a_r5_done_flag_closes: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !go_busy && irq_flag && sample_closed);

  a_r8_abort_keeps_result: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && go_busy && !(wr_bits[0] && wr_bits[1])
    |=> !go_busy && sample_closed && $stable(res_hi_q) && $stable(res_lo_q)
        && $stable(irq_flag));

  a_r10_disabled_no_load: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !conv_done);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_bits(wr_data[1:0]),
  .go_busy(go_busy), .irq_flag(irq_flag), .sample_closed(sample_closed),
  .dac_code(dac_code), .en_q(en_q), .start_acc(start_acc),
  .conv_done(conv_done), .res_hi_q(res_hi_q), .res_lo_q(res_lo_q)
);

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       go_busy, irq_flag, sample_closed;
  logic [9:0] dac_code;
  logic [9:0] vin = 10'd0;
  logic       cmp_in;
  int checks = 0;
  int fails = 0;

  assign cmp_in = (vin >= dac_code);

  sar_conv_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .go_busy(go_busy), .irq_flag(irq_flag),
    .sample_closed(sample_closed), .dac_code(dac_code), .cmp_in(cmp_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [7:0] ctrl_word(input bit go, input bit en, input bit fmt, input logic [1:0] sel);
    return {3'b000, sel, fmt, en, go};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    rd(2'd0, d); chk(d == 8'h00, "R12 ctrl", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R12 hi", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R12 lo", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R12 flag", d, 0);
    chk(sample_closed == 1'b1, "R12 switch", sample_closed, 1);
    chk(dac_code == 10'd0, "R12 dac", dac_code, 0);
  endtask

  task automatic t_same_write_enable();
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'd0));
    wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b0, 2'd0));
    chk(go_busy == 1'b0, "R2 start ignored", go_busy, 0);
    repeat (3) @(negedge clk);
    chk(go_busy == 1'b0 && sample_closed == 1'b1, "R2 still idle", go_busy, 0);
  endtask

  task automatic t_convert(input logic [9:0] v, input bit fmt, input logic [1:0] sel, input int n_div);
    logic [7:0] hi, lo, ehi, elo;
    logic [9:0] first_two;
    int n;
    wr(2'd0, ctrl_word(1'b0, 1'b1, fmt, sel));
    wr(2'd3, 8'h00);
    vin = v;
    wr(2'd0, ctrl_word(1'b1, 1'b1, fmt, sel));
    chk(go_busy == 1'b1 && sample_closed == 1'b0, "R1 start", {go_busy, sample_closed}, 2);
    n = 0;
    first_two = v[9] ? 10'h300 : 10'h100;
    while (go_busy && n < 2000) begin
      @(negedge clk);
      n++;
      if (n == n_div) chk(dac_code == 10'h200, "R4 msb trial", dac_code, 10'h200);
      if (n == 2*n_div) chk(dac_code == first_two, "R4 second trial", dac_code, first_two);
    end
    chk(n == 11*n_div, "R3 conversion cycles", n, 11*n_div);
    chk(irq_flag == 1'b1 && sample_closed == 1'b1, "R5 flag and switch", {irq_flag, sample_closed}, 3);
    if (fmt) begin
      ehi = {6'b0, v[9:8]}; elo = v[7:0];
    end else begin
      ehi = v[9:2]; elo = {v[1:0], 6'b0};
    end
    rd(2'd1, hi); rd(2'd2, lo);
    if (fmt) chk({hi, lo} == {ehi, elo}, "R6 right justify", {hi, lo}, {ehi, elo});
    else     chk({hi, lo} == {ehi, elo}, "R7 left justify", {hi, lo}, {ehi, elo});
  endtask

  task automatic t_abort();
    logic [7:0] hi0, lo0, hi, lo;
    wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 2'd1));
    wr(2'd3, 8'h00);
    rd(2'd1, hi0); rd(2'd2, lo0);
    vin = 10'h0F3;
    wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b1, 2'd1));
    repeat (40) @(negedge clk);
    wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 2'd1));
    chk(go_busy == 1'b0 && sample_closed == 1'b1, "R8 abort stops", {go_busy, sample_closed}, 1);
    rd(2'd1, hi); rd(2'd2, lo);
    chk({hi, lo} == {hi0, lo0}, "R8 result kept", {hi, lo}, {hi0, lo0});
    repeat (100) @(negedge clk);
    chk(irq_flag == 1'b0, "R8 no flag", irq_flag, 0);
    t_convert(10'h0F3, 1'b1, 2'd1, 8);
    chk(1'b1, "R9 restart done", 0, 0);
  endtask

  task automatic t_disabled_storage();
    logic [7:0] hi, lo;
    wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b0, 2'd0));
    wr(2'd3, 8'h00);
    vin = 10'h3C3;
    wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b0, 2'd0));
    repeat (5) @(negedge clk);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd0));
    chk(go_busy == 1'b0, "R10 disable aborts", go_busy, 0);
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    repeat (40) @(negedge clk);
    rd(2'd1, hi); rd(2'd2, lo);
    chk({hi, lo} == 16'hA55A, "R10 storage readback", {hi, lo}, 16'hA55A);
    chk(irq_flag == 1'b0, "R10 no completion", irq_flag, 0);
  endtask

  task automatic t_flag_clash();
    wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 2'd0));
    wr(2'd3, 8'h01);
    wr(2'd3, 8'h00);
    chk(irq_flag == 1'b0, "R11 clear", irq_flag, 0);
    vin = 10'h155;
    wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b1, 2'd0));
    repeat (21) @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk(go_busy == 1'b0 && irq_flag == 1'b1, "R11 completion wins", {go_busy, irq_flag}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_same_write_enable();
    t_convert(10'h2A5, 1'b1, 2'd0, 2);
    t_convert(10'h15A, 1'b0, 2'd1, 8);
    t_convert(10'h3FF, 1'b0, 2'd2, 32);
    t_convert(10'h000, 1'b1, 2'd3, 32);
    t_convert(10'h201, 1'b0, 2'd0, 2);
    t_abort();
    t_disabled_storage();
    t_flag_clash();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule